// File: doc/BRIEF.md
# Per-Core Interrupt Status and Mailbox Register Block

This block holds the inter-processor interrupt state of one core. A 32-bit pending vector records which interrupt sources are waiting. A 32-bit enable mask selects which of them may assert the core's interrupt line. Eight 32-bit mailbox words carry message payloads between cores. The core's own accesses and the writes that other cores post to it arrive on the same simple 32-bit register port. The block decodes the offset, updates the state and returns read data one cycle after a read request.

The pending vector cannot be written directly. Bits are added through a set port and removed through a clear port. The interrupt line is a registered level. A set access raises it when the new pending vector shares a bit with the enable mask. A clear access lowers it only when the pending vector becomes empty while the enable mask is nonzero. In every other cycle the line keeps its value. An access that the block cannot serve produces a one-cycle error strobe.

Top module: `ipi_core_regs`

## Requirements
- R1: After synchronous reset, the pending vector, the enable mask and all mailbox words are zero, and `irq_out`, `err_pulse` and `rd_data` are low.
- R2: A read at offset 0x00 returns the pending vector and a read at 0x04 returns the enable mask. Reads at 0x08 (set port) and 0x0C (clear port) return zero. Read data appears on `rd_data` in the cycle after the request and holds until the next read.
- R3: A write at offset 0x00 leaves the pending vector unchanged and pulses `err_pulse` for one cycle.
- R4: A write at offset 0x08 ORs the write data into the pending vector. If the result ANDed with the enable mask is nonzero, `irq_out` is high from the next cycle.
- R5: A write at offset 0x0C clears each pending bit whose write-data bit is 1. `irq_out` goes low only when the resulting vector is zero and the enable mask is nonzero; otherwise it keeps its value.
- R6: A write at offset 0x04 loads the enable mask and does not change `irq_out` by itself.
- R7: Offsets 0x20 + 4*i, for i from 0 to 7, address eight independent 32-bit mailbox words that can be read and written.
- R8: Misaligned offsets (low two bits nonzero) and every other offset not listed above read zero, change no state on write, and pulse `err_pulse` for one cycle.
- R9: Only address bits 7:0 are decoded, so the upper address bits have no effect on which register is selected.
- R10: A set access whose result shares no bit with the enable mask leaves `irq_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address; only bits 7:0 are decoded |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| err_pulse | output | 1 | One-cycle strobe for a rejected or undefined access |
| irq_out | output | 1 | Interrupt level to the core |

## Verification
The set and clear ports are driven with patterns that separate the asymmetric raise and lower rules. The patterns cover a set with no enabled bit and a set that hits an enabled bit. They cover a partial clear that leaves bits pending, and a full clear under a zero mask compared with a full clear under a nonzero mask. Enable writes are placed between these events to show that the mask alone never moves the line. Each mailbox word gets a distinct value so that swapped or aliased indices show up. Misaligned, unmapped and high-aliased addresses separate offset decoding from the full address.

// File: rtl/ipi_regs_pkg.sv
package ipi_regs_pkg;

    parameter int DATA_W     = 32;
    parameter int DEC_W      = 8;
    parameter int MBOX_WORDS = 8;
    parameter int MBOX_BASE  = 32;

    localparam int MB_IDX_W  = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;
    localparam int MBOX_END  = MBOX_BASE + 4 * MBOX_WORDS;

    localparam int OFF_PEND  = 0;
    localparam int OFF_MASK  = 4;
    localparam int OFF_SET   = 8;
    localparam int OFF_CLR   = 12;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_MASK,
        SEL_SET,
        SEL_CLR,
        SEL_MBOX
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e              sel;
        logic [MB_IDX_W-1:0]   idx;
    } dec_t;

    function automatic dec_t decode_offset(input logic [DEC_W-1:0] off);
        dec_t d;
        int   o;
        o     = int'(off);
        d.sel = SEL_NONE;
        d.idx = '0;
        if (off[1:0] == 2'b00) begin
            if (o == OFF_PEND)      d.sel = SEL_PEND;
            else if (o == OFF_MASK) d.sel = SEL_MASK;
            else if (o == OFF_SET)  d.sel = SEL_SET;
            else if (o == OFF_CLR)  d.sel = SEL_CLR;
            else if (o >= MBOX_BASE && o < MBOX_END) begin
                d.sel = SEL_MBOX;
                d.idx = MB_IDX_W'((o - MBOX_BASE) >> 2);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_regs_pkg::*;
(
    input  logic [DEC_W-1:0] offset,
    output dec_t             dec
);
    always_comb dec = decode_offset(offset);
endmodule

// File: rtl/ipi_status_irq.sv
module ipi_status_irq
    import ipi_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mask,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pend_q,
    output logic [DATA_W-1:0] mask_q,
    output logic              irq_q
);
    logic [DATA_W-1:0] pend_after_set;
    logic [DATA_W-1:0] pend_after_clr;

    always_comb begin
        pend_after_set = pend_q | wdata;
        pend_after_clr = pend_q & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= wdata;
            if (wr_set) begin
                pend_q <= pend_after_set;
                if ((pend_after_set & mask_q) != '0) irq_q <= 1'b1;
            end else if (wr_clr) begin
                pend_q <= pend_after_clr;
                if (pend_after_clr == '0 && mask_q != '0) irq_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
    import ipi_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [MB_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [MB_IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] words [MBOX_WORDS];

    for (genvar g = 0; g < MBOX_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (wr && wr_idx == MB_IDX_W'(g))
                words[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < MBOX_WORDS; i++)
            if (rd_idx == MB_IDX_W'(i)) rdata = words[i];
    end
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
    import ipi_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_pulse,
    output logic              irq_out
);
    dec_t              dec;
    logic              do_wr;
    logic              do_rd;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] mbox_rdata;
    logic [DATA_W-1:0] rd_mux;
    logic              bad_access;
    logic [ADDR_W-1:0] unused_addr;

    assign unused_addr = req_addr;

    ipi_decode u_dec (
        .offset (req_addr[DEC_W-1:0]),
        .dec    (dec)
    );

    assign do_wr = req_valid && req_write;
    assign do_rd = req_valid && !req_write;

    ipi_status_irq u_stat (
        .clk     (clk),
        .rst     (rst),
        .wr_mask (do_wr && dec.sel == SEL_MASK),
        .wr_set  (do_wr && dec.sel == SEL_SET),
        .wr_clr  (do_wr && dec.sel == SEL_CLR),
        .wdata   (req_wdata),
        .pend_q  (pend_q),
        .mask_q  (mask_q),
        .irq_q   (irq_out)
    );

    ipi_mailbox u_mbox (
        .clk    (clk),
        .rst    (rst),
        .wr     (do_wr && dec.sel == SEL_MBOX),
        .wr_idx (dec.idx),
        .wdata  (req_wdata),
        .rd_idx (dec.idx),
        .rdata  (mbox_rdata)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_PEND: rd_mux = pend_q;
            SEL_MASK: rd_mux = mask_q;
            SEL_MBOX: rd_mux = mbox_rdata;
            default:  rd_mux = '0;
        endcase
    end

    assign bad_access = req_valid &&
                        (dec.sel == SEL_NONE || (req_write && dec.sel == SEL_PEND));

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= bad_access;
            if (do_rd) rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/ipi_core_regs_chk.sv
module ipi_core_regs_chk
    import ipi_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              err_pulse,
    input logic              irq_out,
    input logic [DATA_W-1:0] pend_q,
    input logic [DATA_W-1:0] mask_q
);
    logic [7:0] off;
    assign off = req_addr[7:0];

    // R3: pending vector is read-only and the attempt is flagged
    p_pend_readonly_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && off == 8'h00) |=> (err_pulse && $stable(pend_q)));

    // R4: set that hits an enabled bit raises the line
    p_set_raises_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && off == 8'h08 && ((pend_q | req_wdata) & mask_q) != '0)
        |=> irq_out);

    // R5: full clear under a nonzero mask lowers the line
    p_clear_lowers_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && off == 8'h0C && (pend_q & ~req_wdata) == '0 && mask_q != '0)
        |=> !irq_out);

    // R6: a mask write alone never moves the line
    p_mask_keeps_irq_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && off == 8'h04) |=> $stable(irq_out));

    // R8: no access, no error strobe
    p_err_needs_access_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !err_pulse);

    // R4: the line only rises after a set-port write
    p_rise_after_set_r4: assert property (@(posedge clk) disable iff (rst)
        (!(req_valid && req_write && off == 8'h08)) |=> !$rose(irq_out));
endmodule

bind ipi_core_regs ipi_core_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .err_pulse (err_pulse),
    .irq_out   (irq_out),
    .pend_q    (pend_q),
    .mask_q    (mask_q)
);

// File: tb/ipi_core_regs_bench.sv
`timescale 1ns/1ps
module ipi_core_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        err_pulse;
    logic        irq_out;

    always #4 clk = ~clk;

    ipi_core_regs u_ipi_core_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .err_pulse (err_pulse),
        .irq_out   (irq_out)
    );

    // behavioural reference
    int unsigned m_pend, m_mask, m_rd;
    int unsigned m_mb [8];
    bit          m_irq, m_err;
    bit          started = 0;
    int          checks = 0;
    int          errors = 0;
    string       cur_req = "R1";
    bit          done = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_pend = 0; m_mask = 0; m_rd = 0; m_irq = 0; m_err = 0;
            foreach (m_mb[i]) m_mb[i] = 0;
        end else begin
            int a;
            int unsigned nv;
            bit known;
            a = int'(req_addr[7:0]);
            m_err = 0;
            known = (a % 4 == 0) && (a <= 12 || (a >= 32 && a < 64));
            if (req_valid) begin
                if (!known || (req_write && a == 0)) m_err = 1;
                if (req_write && known) begin
                    if (a == 4) m_mask = req_wdata;
                    else if (a == 8) begin
                        nv = m_pend | req_wdata;
                        if ((nv & m_mask) != 0) m_irq = 1;
                        m_pend = nv;
                    end else if (a == 12) begin
                        nv = m_pend & ~req_wdata;
                        if (nv == 0 && m_mask != 0) m_irq = 0;
                        m_pend = nv;
                    end else if (a >= 32) m_mb[(a - 32) / 4] = req_wdata;
                end else if (!req_write) begin
                    if (!known) m_rd = 0;
                    else if (a == 0) m_rd = m_pend;
                    else if (a == 4) m_rd = m_mask;
                    else if (a >= 32) m_rd = m_mb[(a - 32) / 4];
                    else m_rd = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (rd_data !== m_rd || err_pulse !== m_err || irq_out !== m_irq) begin
                errors++;
                $display("FAIL %s: rd=%h err=%b irq=%b expected rd=%h err=%b irq=%b",
                         cur_req, rd_data, err_pulse, irq_out, m_rd, m_err, m_irq);
            end
        end
    end

    task automatic acc(input bit w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic named(input string tag, input bit ok, input logic [31:0] act,
                         input logic [31:0] exp);
        @(negedge clk);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        acc(0, 12'h000, 0); named("R1", rd_data == 0 && !irq_out, rd_data, 0);
        acc(0, 12'h004, 0); acc(0, 12'h03C, 0);

        cur_req = "R2";
        acc(1, 12'h004, 32'h0000_00F0);
        acc(0, 12'h004, 0); named("R2", rd_data == 32'hF0, rd_data, 32'hF0);
        acc(0, 12'h008, 0); acc(0, 12'h00C, 0);

        cur_req = "R10";
        acc(1, 12'h008, 32'h1);
        named("R10", !irq_out, irq_out, 0);
        cur_req = "R4";
        acc(1, 12'h008, 32'h10);
        named("R4", irq_out, irq_out, 1);
        acc(0, 12'h000, 0); named("R4", rd_data == 32'h11, rd_data, 32'h11);

        cur_req = "R3";
        acc(1, 12'h000, 32'hFFFF_FFFF);
        acc(0, 12'h000, 0); named("R3", rd_data == 32'h11, rd_data, 32'h11);

        cur_req = "R5";
        acc(1, 12'h00C, 32'h10); named("R5", irq_out, irq_out, 1);
        acc(1, 12'h00C, 32'h01); named("R5", !irq_out, irq_out, 0);
        acc(1, 12'h004, 32'h0);
        acc(1, 12'h008, 32'h4);
        cur_req = "R6";
        acc(1, 12'h004, 32'h4); named("R6", !irq_out, irq_out, 0);
        acc(1, 12'h008, 32'h0); named("R6", irq_out, irq_out, 1);
        acc(1, 12'h004, 32'h0);
        cur_req = "R5";
        acc(1, 12'h00C, 32'h4); named("R5", irq_out, irq_out, 1);
        acc(1, 12'h004, 32'h1); named("R6", irq_out, irq_out, 1);
        acc(1, 12'h00C, 32'h0); named("R5", !irq_out, irq_out, 0);

        cur_req = "R7";
        for (int i = 0; i < 8; i++)
            acc(1, 12'(32 + 4 * i), 32'hA500_0000 | (32'h1_1111 * i));
        for (int i = 0; i < 8; i++) begin
            acc(0, 12'(32 + 4 * i), 0);
            named("R7", rd_data == (32'hA500_0000 | (32'h1_1111 * i)), rd_data,
                  32'hA500_0000 | (32'h1_1111 * i));
        end

        cur_req = "R8";
        acc(0, 12'h010, 0); named("R8", rd_data == 0, rd_data, 0);
        acc(1, 12'h014, 32'hDEAD);
        acc(0, 12'h022, 0);
        acc(1, 12'h021, 32'h1234);
        acc(0, 12'h020, 0); named("R8", rd_data == 32'hA500_0000, rd_data, 32'hA500_0000);
        acc(1, 12'h040, 32'h5555);
        acc(1, 12'h009, 32'hFF);
        acc(0, 12'h000, 0); named("R8", rd_data == 0, rd_data, 0);

        cur_req = "R9";
        acc(1, 12'h520, 32'hCAFE_F00D);
        acc(0, 12'h320, 0); named("R9", rd_data == 32'hCAFE_F00D, rd_data, 32'hCAFE_F00D);
        acc(1, 12'hF08, 32'h1); named("R9", irq_out, irq_out, 1);

        cur_req = "R1";
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        acc(0, 12'h020, 0); named("R1", rd_data == 0 && !irq_out, rd_data, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule